// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a byte-wide bank of 256 configuration registers and exposes them to a host through a pair of neighbouring I/O addresses. The lower address is the selector: a byte written there picks which register the next access touches. The upper address is the data window: a write there lands in the picked register, and a read returns it. The host bus is reduced to an address, a write strobe, a read strobe and a data byte in each direction. Only single-byte accesses are supported.

Not every register accepts data. A fixed map marks most indexes as read-only, and their writes are discarded. Two indexes take one particular byte value only and discard any other value. The whole window is opened and closed by one bit of a control register inside a neighbouring bridge. The block watches the bridge's control writes and keeps the most recent value of that bit. While the window is closed, writes do nothing and reads return all ones.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the selector is 0x00, the window is closed, the read data output is 0x00, and the registers hold E0h=3Ch, E2h=03h, E3h=FCh, E6h=DEh, E7h=FEh, E8h=BEh and 00h in every other index.
- R2: The window is open exactly while bit 1 of the last byte written to bridge control offset 0x85 is 1; bridge writes to any other offset leave the window state unchanged.
- R3: With the window open, a write strobe at address 0x3F0 loads the whole data byte into the selector.
- R4: With the window open, a write strobe at address 0x3F1 stores the data byte into the selected register when that index is E0h-E3h, E6h, EEh-F2h, F4h, F6h, F8h or FCh.
- R5: Indexes 00h-DFh, E4h, E5h, E9h-EDh, F3h, F5h, F7h, F9h-FBh and FDh-FFh discard data-port writes and always read as 00h.
- R6: Index E7h stores only the value FEh and index E8h stores only the value BEh; any other value written to either is discarded.
- R7: A read strobe at 0x3F0 or 0x3F1 with the window open places the register at the current selector on the read data output one clock later; the output then holds until the next read strobe at one of those two addresses.
- R8: With the window closed, write strobes change neither the selector nor any register, and a read strobe at 0x3F0 or 0x3F1 places FFh on the read data output one clock later.
- R9: Strobes at any address other than 0x3F0 and 0x3F1 change neither the selector, the registers nor the read data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data byte |
| host_rdata | output | 8 | Registered read data byte |
| brg_wr | input | 1 | Bridge control register write strobe |
| brg_off | input | 8 | Bridge control register offset being written |
| brg_wdata | input | 8 | Bridge control register write data |

## Verification
A full sweep reads all 256 indexes straight after reset and then writes a distinct pattern to each one, which separates the writable, read-only and fixed-value groups and exposes a protection map that is off by one at any range edge. Directed sequences toggle the window through the bridge offset and through decoy offsets, hit the two fixed-value indexes with both the accepted byte and near misses, and strobe neighbouring addresses, which tells a gated or misdecoded access apart from a valid one. A long seeded random mix of bridge writes, selector writes, data writes and reads at both window and stray addresses then compares every returned byte with a model, catching ordering faults such as a read that sees a stale selector or a closed window that still updates state.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam int unsigned REG_W    = 8;
   localparam int unsigned IDX_W    = 8;
   localparam int unsigned NUM_REGS = 1 << IDX_W;

   typedef enum logic [1:0] {
      ACC_RO    = 2'd0,
      ACC_RW    = 2'd1,
      ACC_FIXED = 2'd2
   } acc_kind_e;

   // Access class of each index in the bank.
   function automatic acc_kind_e acc_kind(input logic [IDX_W-1:0] idx);
      if (idx < 8'hE0) return ACC_RO;
      case (idx)
         8'hE7, 8'hE8:                         return ACC_FIXED;
         8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
         8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
         8'hF4, 8'hF6, 8'hF8, 8'hFC:           return ACC_RW;
         default:                              return ACC_RO;
      endcase
   endfunction

   // Value loaded at reset.
   function automatic logic [REG_W-1:0] init_val(input logic [IDX_W-1:0] idx);
      case (idx)
         8'hE0:   return 8'h3C;
         8'hE2:   return 8'h03;
         8'hE3:   return 8'hFC;
         8'hE6:   return 8'hDE;
         8'hE7:   return 8'hFE;
         8'hE8:   return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   // Single byte accepted by a fixed-value index.
   function automatic logic [REG_W-1:0] only_val(input logic [IDX_W-1:0] idx);
      case (idx)
         8'hE7:   return 8'hFE;
         8'hE8:   return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfgp_win_ctl.sv
module cfgp_win_ctl #(
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned CTRL_OFF = 'h85,
   parameter int unsigned EN_BIT   = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     brg_wr,
   input  logic [OFF_W-1:0]         brg_off,
   input  logic [cfgp_pkg::REG_W-1:0] brg_wdata,
   output logic                     win_en_o
);

   logic hit;
   logic unused_bits;

   assign hit         = brg_wr && (brg_off == OFF_W'(CTRL_OFF));
   assign unused_bits = ^brg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)   win_en_o <= 1'b0;
      else if (hit) win_en_o <= brg_wdata[EN_BIT];
   end

endmodule

// File: rtl/cfgp_host_dec.sv
module cfgp_host_dec #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE_ADDR = 'h3F0
) (
   input  logic              win_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic              idx_we,
   output logic              dat_we,
   output logic              rd_upd,
   output logic              rd_live
);

   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR + 1);

   logic at_sel;
   logic at_dat;

   assign at_sel  = (host_addr == SEL_ADDR);
   assign at_dat  = (host_addr == DAT_ADDR);

   assign idx_we  = win_en && host_wr && at_sel;
   assign dat_we  = win_en && host_wr && at_dat;
   assign rd_upd  = host_rd && (at_sel || at_dat);
   assign rd_live = rd_upd && win_en;

endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
   import cfgp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata
);

   logic [REG_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [IDX_W-1:0] IDX  = IDX_W'(i);
      localparam acc_kind_e        KIND = acc_kind(IDX);
      localparam logic [REG_W-1:0] RST  = init_val(IDX);
      localparam logic [REG_W-1:0] ONLY = only_val(IDX);

      if (KIND == ACC_RO) begin : g_ro
         assign regs[i] = RST;
      end else begin : g_store
         logic             sel;
         logic             ok;
         logic [REG_W-1:0] q;

         assign sel = we && (idx == IDX);
         if (KIND == ACC_FIXED) begin : g_fixed
            assign ok = (wdata == ONLY);
         end else begin : g_free
            assign ok = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)        q <= RST;
            else if (sel && ok) q <= wdata;
         end
         assign regs[i] = q;
      end
   end

   assign rdata = regs[idx];

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE_ADDR = 'h3F0,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned CTRL_OFF  = 'h85,
   parameter int unsigned EN_BIT    = 1,
   parameter logic [7:0]  IDLE_RD   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              brg_wr,
   input  logic [OFF_W-1:0]  brg_off,
   input  logic [7:0]        brg_wdata
);
   import cfgp_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr_w
      $error("cfg_index_port: ADDR_W out of range");
   end
   if (BASE_ADDR >= (32'd1 << ADDR_W) - 1) begin : g_bad_base
      $error("cfg_index_port: port pair does not fit the address width");
   end
   if (EN_BIT >= REG_W) begin : g_bad_bit
      $error("cfg_index_port: EN_BIT outside the control byte");
   end
   if (OFF_W < 1 || CTRL_OFF >= (32'd1 << OFF_W)) begin : g_bad_off
      $error("cfg_index_port: CTRL_OFF does not fit OFF_W");
   end

   logic             win_en;
   logic             idx_we;
   logic             dat_we;
   logic             rd_upd;
   logic             rd_live;
   logic [IDX_W-1:0] idx_q;
   logic [REG_W-1:0] bank_rd;

   cfgp_win_ctl #(
      .OFF_W    (OFF_W),
      .CTRL_OFF (CTRL_OFF),
      .EN_BIT   (EN_BIT)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .brg_wr    (brg_wr),
      .brg_off   (brg_off),
      .brg_wdata (brg_wdata),
      .win_en_o  (win_en)
   );

   cfgp_host_dec #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .win_en    (win_en),
      .host_addr (host_addr),
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .idx_we    (idx_we),
      .dat_we    (dat_we),
      .rd_upd    (rd_upd),
      .rd_live   (rd_live)
   );

   cfgp_regbank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dat_we),
      .idx   (idx_q),
      .wdata (host_wdata),
      .rdata (bank_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= host_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      host_rdata <= '0;
      else if (rd_upd) host_rdata <= rd_live ? bank_rd : IDLE_RD;
   end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE_ADDR = 'h3F0,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned CTRL_OFF  = 'h85,
   parameter int unsigned EN_BIT    = 1,
   parameter logic [7:0]  IDLE_RD   = 8'hFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [7:0]        host_wdata,
   input logic [7:0]        host_rdata,
   input logic              brg_wr,
   input logic [OFF_W-1:0]  brg_off,
   input logic [7:0]        brg_wdata,
   input logic              win_en,
   input logic [7:0]        idx_q
);

   logic at_pair;
   logic ctl_hit;
   logic sel_wr;
   logic unused_bits;

   assign at_pair     = (host_addr == ADDR_W'(BASE_ADDR)) ||
                        (host_addr == ADDR_W'(BASE_ADDR + 1));
   assign ctl_hit     = brg_wr && (brg_off == OFF_W'(CTRL_OFF));
   assign sel_wr      = win_en && host_wr && (host_addr == ADDR_W'(BASE_ADDR));
   assign unused_bits = ^brg_wdata;

   // R2: window follows the enable bit of each control write
   a_r2_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> (win_en == $past(brg_wdata[EN_BIT])));

   // R2: other bridge traffic leaves the window alone
   a_r2_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_hit |=> $stable(win_en));

   // R3: selector load
   a_r3_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (idx_q == $past(host_wdata)));

   // R8/R9: selector frozen without an open selector write
   a_r8_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(idx_q));

   // R8: closed window reads return the idle byte
   a_r8_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_en && host_rd && at_pair) |=> (host_rdata == IDLE_RD));

   // R7/R9: read data holds between decoded reads
   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && at_pair) |=> $stable(host_rdata));

endmodule

bind cfg_index_port cfgp_checker #(
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .OFF_W     (OFF_W),
   .CTRL_OFF  (CTRL_OFF),
   .EN_BIT    (EN_BIT),
   .IDLE_RD   (IDLE_RD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .brg_wr     (brg_wr),
   .brg_off    (brg_off),
   .brg_wdata  (brg_wdata),
   .win_en     (win_en),
   .idx_q      (idx_q)
);

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;

   localparam logic [15:0] SEL = 16'h03F0;
   localparam logic [15:0] DAT = 16'h03F1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        brg_wr = 1'b0;
   logic [7:0]  brg_off = '0;
   logic [7:0]  brg_wdata = '0;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   logic [7:0] model [256];
   logic [7:0] m_idx;
   logic       m_en;
   logic [7:0] m_rd;

   always #2 clk = ~clk;

   cfg_index_port u_cfg_index_port (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .brg_wr(brg_wr), .brg_off(brg_off), .brg_wdata(brg_wdata)
   );

   // 0 read-only, 1 free, 2 single-value
   function automatic int kind_of(input logic [7:0] i);
      if (i == 8'hE7 || i == 8'hE8) return 2;
      if (i inside {[8'hE0:8'hE3], 8'hE6, [8'hEE:8'hF2], 8'hF4, 8'hF6, 8'hF8, 8'hFC})
         return 1;
      return 0;
   endfunction

   function automatic logic [7:0] rst_of(input logic [7:0] i);
      case (i)
         8'hE0: return 8'h3C;  8'hE2: return 8'h03;  8'hE3: return 8'hFC;
         8'hE6: return 8'hDE;  8'hE7: return 8'hFE;  8'hE8: return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] accept_of(input logic [7:0] i);
      return (i == 8'hE7) ? 8'hFE : 8'hBE;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic brg_write(input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      brg_wr = 1'b1; brg_off = off; brg_wdata = d;
      if (off == 8'h85) m_en = d[1];
      @(negedge clk);
      brg_wr = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      if (m_en && a == SEL) m_idx = d;
      else if (m_en && a == DAT) begin
         if (kind_of(m_idx) == 1) model[m_idx] = d;
         else if (kind_of(m_idx) == 2 && d == accept_of(m_idx)) model[m_idx] = d;
      end
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [15:0] a, input string req);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      if (a == SEL || a == DAT) m_rd = m_en ? model[m_idx] : 8'hFF;
      @(negedge clk);
      host_rd = 1'b0;
      chk(req, host_rdata, m_rd);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 256; i++) model[i] = rst_of(8'(i));
      m_idx = 8'h00; m_en = 1'b0; m_rd = 8'h00;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata after reset", host_rdata, 8'h00);

      // closed window after reset, decoy offsets
      host_read(DAT, "R8 closed after reset");
      brg_write(8'h84, 8'hFF);
      brg_write(8'h05, 8'h02);
      host_read(SEL, "R2 decoy offsets keep window closed");
      brg_write(8'h85, 8'h02);
      host_read(DAT, "R1 selector zero reads index 00");
      brg_write(8'h85, 8'hFD);
      host_read(DAT, "R2 bit1 clear closes window");
      brg_write(8'h85, 8'h02);

      // R1 sweep of reset contents
      for (int i = 0; i < 256; i++) begin
         host_write(SEL, 8'(i));
         host_read(DAT, "R1 reset value");
      end

      // R4/R5/R6 pattern write to every index
      for (int i = 0; i < 256; i++) begin
         host_write(SEL, 8'(i));
         host_write(DAT, 8'(i) ^ 8'h5A);
         case (kind_of(8'(i)))
            0: host_read(DAT, "R5 read-only discards");
            1: host_read(DAT, "R4 writable stores");
            default: host_read(DAT, "R6 single-value rejects");
         endcase
      end

      // R6 accepted values and near misses
      host_write(SEL, 8'hE7); host_write(DAT, 8'hFF); host_read(DAT, "R6 E7 near miss");
      host_write(DAT, 8'hFE); host_read(DAT, "R6 E7 accepted");
      host_write(SEL, 8'hE8); host_write(DAT, 8'hBF); host_read(DAT, "R6 E8 near miss");
      host_write(DAT, 8'hBE); host_read(DAT, "R6 E8 accepted");

      // R7 selector-port read and hold
      host_write(SEL, 8'hE6); host_write(DAT, 8'h77);
      host_read(SEL, "R7 read at selector address");
      repeat (3) @(negedge clk);
      chk("R7 rdata holds", host_rdata, 8'h77);

      // R8 closed window freezes state
      brg_write(8'h85, 8'h00);
      host_write(SEL, 8'hF0);
      host_write(DAT, 8'h11);
      host_read(DAT, "R8 closed read idle");
      brg_write(8'h85, 8'h02);
      host_read(DAT, "R8 state unchanged while closed");

      // R9 stray addresses
      host_write(16'h03F2, 8'hF0);
      host_write(16'h03EF, 8'h22);
      host_write(16'h13F1, 8'h33);
      host_read(16'h03F2, "R9 stray read holds output");
      host_read(DAT, "R9 stray writes ignored");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int op;
         logic [7:0] v;
         op = int'($urandom_range(0, 99));
         v  = 8'($urandom);
         if (op < 6) begin
            brg_write(($urandom_range(0, 3) != 0) ? 8'h85 : v,
                      ($urandom_range(0, 4) != 0) ? (8'($urandom) | 8'h02) : 8'($urandom));
         end else if (op < 30) begin
            host_write(SEL, ($urandom_range(0, 3) != 0) ? (8'hE0 | (v & 8'h1F)) : v);
         end else if (op < 55) begin
            if ($urandom_range(0, 3) == 0) v = (v[0]) ? 8'hFE : 8'hBE;
            host_write(DAT, v);
         end else if (op < 90) begin
            host_read(($urandom_range(0, 1) != 0) ? DAT : SEL, "R7 random read");
         end else if (op < 95) begin
            host_write(16'h03F0 ^ (16'h1 << $urandom_range(1, 15)), v);
         end else begin
            host_read(16'h03F1 ^ (16'h1 << $urandom_range(1, 15)), "R9 random stray read");
         end
      end

      done = 1;
      summary();
      $finish;
   end

endmodule